// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits beside the fetch stage of an in-order core and guesses where fetch goes next. The current fetch address is looked up in a direct-mapped table every cycle. If a valid entry's tag matches, the branch is predicted taken and the stored target is offered as the next fetch address. Otherwise the next address is simply the fetch address plus one instruction length. There is no direction history, so every hit counts as a taken prediction.

Each resolved branch is reported on a resolution port with its address, its outcome and its actual target. The block compares this against what the table would have predicted for that address.

- A taken branch always writes its target into the entry selected by its address, which allocates the entry or corrects it.
- A not-taken branch never touches the table.
- When the prediction was wrong, the block raises a single-cycle flush toward the prefetch queue, together with the address to restart from.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous reset every entry is invalid: all lookups miss and `flush` is 0.
- R2: A lookup that misses gives `pred_hit`=0 and `pred_next_pc` = `fetch_pc` + `INSTR_BYTES`, in the same cycle as `fetch_pc`.
- R3: A taken resolution writes its target into the entry at index `res_pc[ALIGN_BITS+IDX_W-1:ALIGN_BITS]`, with tag `res_pc[ADDR_W-1:ALIGN_BITS+IDX_W]`. From the next clock edge a lookup of that address gives `pred_hit`=1 and `pred_next_pc` = that target.
- R4: A lookup hits only when the entry is valid and its stored tag equals the upper bits of `fetch_pc`. An address that aliases to the same index with a different tag misses.
- R5: A taken resolution mispredicts in two cases: the address misses, or the address hits with a stored target different from the actual one. After the next edge `flush`=1 and `flush_pc` = actual target, and the entry holds the actual target.
- R6: A not-taken resolution on a hitting address gives `flush`=1 and `flush_pc` = `res_pc` + `INSTR_BYTES` after the next edge. The entry keeps its old target and still hits.
- R7: A not-taken resolution on a missing address allocates nothing and raises no flush.
- R8: A taken resolution that hits with the correct target raises no flush.
- R9: `flush` is high for exactly one cycle per mispredicting resolution. It is 0 in the cycle after any edge at which `res_valid` was 0.
- R10: If an update and a lookup address the same entry in one cycle, the lookup returns the contents from before the update.
- R11: A loop that closes with one backward branch and runs N iterations from a cold table mispredicts exactly twice: on the first taken resolution and on the final not-taken one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_hit | output | 1 | Lookup hit, predicted taken |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| res_valid | input | 1 | A branch resolution is presented |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Resolved branch was taken |
| res_target | input | ADDR_W | Actual target of the resolved branch |
| flush | output | 1 | One-cycle flush-and-redirect request |
| flush_pc | output | ADDR_W | Restart address that goes with `flush` |

## Verification
The bench builds the block with `ADDR_W`=12, `ENTRIES`=8, `ALIGN_BITS`=2 and `INSTR_BYTES`=4. With these values the whole aligned address space is only 1024 lookups, so the bench can compare every one of them against an arithmetic model of the table after random traffic. The small index lets the random traffic alias constantly, which exercises tag mismatch, target replacement and false hits far more often than the default 256 entries would. The directed cases cover the same-cycle update and lookup, and the loop whose exit mispredicts.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Classification of one resolved branch against the table's prediction.
  typedef enum logic [1:0] {
    RES_CORRECT      = 2'd0,
    RES_COLD_TAKEN   = 2'd1,
    RES_WRONG_TARGET = 2'd2,
    RES_FALSE_HIT    = 2'd3
  } res_kind_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 22,
  parameter int ADDR_W = 32,
  parameter int NRD    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [ADDR_W-1:0]           wr_target,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NRD-1:0]              rd_valid,
  output logic [NRD-1:0][TAG_W-1:0]   rd_tag,
  output logic [NRD-1:0][ADDR_W-1:0]  rd_target
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int EW    = TAG_W + ADDR_W;

  logic [DEPTH-1:0] valid_q;
  logic [EW-1:0]    mem [DEPTH];

  // Valid bits: the only state that reset touches.
  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // Tag and target storage, no reset, a single write port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_target};
  end

  // Asynchronous read ports: fetch lookup and resolution check.
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_valid[g]                = valid_q[rd_idx[g]];
    assign {rd_tag[g], rd_target[g]}  = mem[rd_idx[g]];
  end

  // R3: a written entry is valid after the edge.
  a_r3_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int TAG_W  = 22,
  parameter int ADDR_W = 32
) (
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_target,
  input  logic [TAG_W-1:0]  probe_tag,
  output logic              hit,
  output logic [ADDR_W-1:0] target
);
  always_comb begin
    hit    = ent_valid && (ent_tag == probe_tag);
    target = ent_target;
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              look_hit,
  input  logic [ADDR_W-1:0] look_target,
  output logic              upd_en,
  output logic              flush_o,
  output logic [ADDR_W-1:0] flush_pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  res_kind_e         kind;
  logic              mispredict;
  logic [ADDR_W-1:0] restart_pc;

  always_comb begin
    if (!look_hit)                    kind = res_taken ? RES_COLD_TAKEN : RES_CORRECT;
    else if (!res_taken)              kind = RES_FALSE_HIT;
    else if (look_target != res_target) kind = RES_WRONG_TARGET;
    else                              kind = RES_CORRECT;
    mispredict = res_valid && (kind != RES_CORRECT);
    restart_pc = res_taken ? res_target : (res_pc + STEP);
    upd_en     = res_valid && res_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_o    <= 1'b0;
      flush_pc_o <= '0;
    end else begin
      flush_o <= mispredict;
      if (mispredict) flush_pc_o <= restart_pc;
    end
  end

  // R5: taken with a wrong stored target redirects to the actual target.
  a_r5_wrong_target_flush: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken && look_hit && look_target != res_target)
      |=> (flush_o && flush_pc_o == $past(res_target)));
  // R6: not taken on a hit restarts at the fall-through address.
  a_r6_false_hit_flush: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken && look_hit)
      |=> (flush_o && flush_pc_o == $past(res_pc) + STEP));
  // R7: not taken on a miss is silent.
  a_r7_quiet_miss: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken && !look_hit) |=> !flush_o);
  // R8: correct taken prediction is silent.
  a_r8_correct_quiet: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken && look_hit && look_target == res_target) |=> !flush_o);
  // R9: no resolution, no flush in the next cycle.
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !flush_o);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 256,
  parameter int ALIGN_BITS  = 2,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TAG_LSB = ALIGN_BITS + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int NPORT   = 2;   // port 0: fetch lookup, port 1: resolution check

  logic [NPORT-1:0][ADDR_W-1:0] port_pc;
  logic [NPORT-1:0][IDX_W-1:0]  port_idx;
  logic [NPORT-1:0]             port_valid;
  logic [NPORT-1:0][TAG_W-1:0]  port_tag;
  logic [NPORT-1:0][ADDR_W-1:0] port_tgt;
  logic [NPORT-1:0]             port_hit;
  logic [NPORT-1:0][ADDR_W-1:0] port_hit_tgt;
  logic                         upd_en;

  assign port_pc[0] = fetch_pc;
  assign port_pc[1] = res_pc;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_idx[p] = port_pc[p][TAG_LSB-1:ALIGN_BITS];
    btb_match #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_match (
      .ent_valid  (port_valid[p]),
      .ent_tag    (port_tag[p]),
      .ent_target (port_tgt[p]),
      .probe_tag  (port_pc[p][ADDR_W-1:TAG_LSB]),
      .hit        (port_hit[p]),
      .target     (port_hit_tgt[p])
    );
  end

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .NRD(NPORT)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (upd_en),
    .wr_idx    (port_idx[1]),
    .wr_tag    (res_pc[ADDR_W-1:TAG_LSB]),
    .wr_target (res_target),
    .rd_idx    (port_idx),
    .rd_valid  (port_valid),
    .rd_tag    (port_tag),
    .rd_target (port_tgt)
  );

  btb_resolve #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_resolve (
    .clk         (clk),
    .rst         (rst),
    .res_valid   (res_valid),
    .res_pc      (res_pc),
    .res_taken   (res_taken),
    .res_target  (res_target),
    .look_hit    (port_hit[1]),
    .look_target (port_hit_tgt[1]),
    .upd_en      (upd_en),
    .flush_o     (flush),
    .flush_pc_o  (flush_pc)
  );

  always_comb begin
    pred_hit     = port_hit[0];
    pred_next_pc = port_hit[0] ? port_hit_tgt[0] : (fetch_pc + ADDR_W'(INSTR_BYTES));
  end

  // R1: the cycle after reset has no flush pending.
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !flush);
endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int AW = 12, ENT = 8, AL = 2, IB = 4;
  localparam int IW = 3;

  logic          clk = 0, rst = 1;
  logic [AW-1:0] fetch_pc = '0, res_pc = '0, res_target = '0;
  logic          res_valid = 0, res_taken = 0;
  logic          pred_hit, flush;
  logic [AW-1:0] pred_next_pc, flush_pc;

  int checks = 0, errors = 0;
  bit m_valid [ENT];
  logic [AW-1:0] m_pc [ENT];   // full address of the allocating branch
  logic [AW-1:0] m_tgt [ENT];
  int flush_count;

  always #5 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .ENTRIES(ENT), .ALIGN_BITS(AL), .INSTR_BYTES(IB)) dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_next_pc(pred_next_pc), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .flush(flush), .flush_pc(flush_pc));

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [AW-1:0] a);
    return int'(a[AL+IW-1:AL]);
  endfunction
  function automatic bit m_hit(input logic [AW-1:0] a);
    int i = idx_of(a);
    return m_valid[i] && (m_pc[i][AW-1:AL+IW] == a[AW-1:AL+IW]);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1; res_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < ENT; i++) m_valid[i] = 0;
    #1 chk(flush == 0, "R1 flush after reset", AW'(flush), 0);
  endtask

  // Present one resolution, check flush after the edge and the quiet cycle after.
  task automatic do_res(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tg);
    bit hit = m_hit(pc);
    int i = idx_of(pc);
    bit exp_fl;
    logic [AW-1:0] exp_pc;
    string req;
    if (!hit) begin exp_fl = tk; req = tk ? "R5 cold taken" : "R7 quiet miss"; end
    else if (!tk) begin exp_fl = 1; req = "R6 false hit"; end
    else if (m_tgt[i] != tg) begin exp_fl = 1; req = "R5 wrong target"; end
    else begin exp_fl = 0; req = "R8 correct hit"; end
    exp_pc = tk ? tg : pc + AW'(IB);
    @(negedge clk);
    res_valid = 1; res_pc = pc; res_taken = tk; res_target = tg;
    @(posedge clk); #1;
    chk(flush == exp_fl, req, AW'(flush), AW'(exp_fl));
    if (exp_fl) begin
      flush_count++;
      chk(flush_pc == exp_pc, {req, " restart"}, flush_pc, exp_pc);
    end
    if (tk) begin m_valid[i] = 1; m_pc[i] = pc; m_tgt[i] = tg; end
    @(negedge clk); res_valid = 0;
    @(posedge clk); #1;
    chk(flush == 0, "R9 single pulse", AW'(flush), 0);
  endtask

  task automatic look(input logic [AW-1:0] a, input string req);
    bit h = m_hit(a);
    logic [AW-1:0] nx = h ? m_tgt[idx_of(a)] : a + AW'(IB);
    fetch_pc = a; #1;
    chk(pred_hit == h, {req, " hit"}, AW'(pred_hit), AW'(h));
    chk(pred_next_pc == nx, {req, " next"}, pred_next_pc, nx);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < (1 << (AW - AL)); a++) look(AW'(a << AL), req);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    sweep("R1/R2 cold");                                // R1, R2: everything misses
    // R3 allocation, R4 alias, R8 correct hit
    do_res(12'h104, 1, 12'h040);
    look(12'h104, "R3 allocated");
    look(12'h124, "R4 alias miss");                     // same index, other tag
    do_res(12'h104, 1, 12'h040);                        // R8
    do_res(12'h104, 1, 12'h080);                        // R5 wrong target, corrected
    look(12'h104, "R5 corrected");
    do_res(12'h104, 0, 12'h000);                        // R6, entry kept
    look(12'h104, "R6 entry kept");
    do_res(12'h208, 0, 12'h000);                        // R7 miss not taken
    look(12'h208, "R7 no alloc");
    // R10: update and lookup of the same entry in one cycle
    @(negedge clk);
    fetch_pc = 12'h104; res_valid = 1; res_pc = 12'h104; res_taken = 1; res_target = 12'h3f0;
    #1 chk(pred_next_pc == 12'h080, "R10 old contents", pred_next_pc, 12'h080);
    @(posedge clk); #1;
    chk(pred_next_pc == 12'h3f0, "R10 new after edge", pred_next_pc, 12'h3f0);
    m_tgt[idx_of(12'h104)] = 12'h3f0;
    @(negedge clk); res_valid = 0;
    // Random traffic over a small aliasing address set
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] pc = AW'({$urandom_range(0, 31)} << AL);
      logic [AW-1:0] tg = AW'({$urandom_range(0, 3)} << (AL + 4));
      do_res(pc, 1'($urandom_range(0, 2) != 0), tg);
    end
    sweep("R3/R4 model");
    // R11: loop from a cold table
    do_reset();
    sweep("R1 after second reset");
    flush_count = 0;
    for (int it = 0; it < 10; it++) do_res(12'h3c0, it < 9, 12'h300);
    chk(flush_count == 2, "R11 loop mispredicts", AW'(flush_count), 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule